// File: doc/BRIEF.md
# Staged Dual-Channel Phase Generator

This block runs two numerically controlled oscillators side by side. Software programs each channel's 32-bit frequency step and 16-bit phase offset through a 16-bit register write port. Every value lands first in a shadow copy and reaches the running oscillators only when a synchronisation bit is driven from 0 to 1. That same event restarts both phase accumulators from zero, so the two channels begin together with a known relative phase.

Each clock, every channel adds its active frequency step to a 32-bit accumulator, modulo 2^32. The phase word it drives out is the upper 16 accumulator bits plus the active phase offset, modulo 2^16. A sine lookup would take these words as its address. A control register gates both outputs to zero. A combinational read port returns the staged contents of the registers.

Top module: `nco_dual_stage`

## Requirements
- R1: After the asynchronous reset, all registers, shadow copies, active settings and accumulators are zero. Both phase outputs read 0, and every register reads back 0.
- R2: The 32-bit frequency step of channel 0 is written as a low half at address 0x14 and a high half at 0x15. Channel 1 uses 0x16 for the low half and 0x17 for the high half. A read of any of these addresses returns the staged half.
- R3: The 16-bit phase offset of channel 0 is at address 0x13 minus one (0x12). The offset of channel 1 is at 0x13. A read returns the staged value.
- R4: A write to a frequency or phase address changes only the shadow copy. The phase outputs keep following the previously active settings until a sync event.
- R5: A sync event is a write to address 0x1F whose bit 1 is 1 while the stored bit 1 of 0x1F is 0. A write with bit 1 set while the stored bit is already 1 neither loads new settings nor clears the accumulators.
- R6: On a sync event, both channels copy all shadow values into their active settings and clear their accumulators. In the cycle after the event, each enabled output equals its new phase offset.
- R7: In every cycle without a sync event, each accumulator grows by its active frequency step modulo 2^32. Each output equals accumulator bits 31..16 plus the active phase offset, modulo 2^16.
- R8: The outputs are enabled only while bit 6 and bit 4 of the control register at 0x02 are both 1. Otherwise both outputs read 0, and the accumulators keep running.
- R9: Addresses 0x02 and 0x1F read back all 16 written bits. Every unmapped address reads 0.
- R10: The read data follows the read address combinationally. A write becomes visible on the read port from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 16 | Staged contents of the addressed register |
| phase_o | output | 2x16 | Phase word per channel, channel 0 in bits 15..0 |

## Verification
Two things can land on the same clock edge: a sync event and the normal accumulation step. The accumulator clear must win over the add, and the copy into the active settings must take the shadow values held before that edge. The bench programs new steps, raises the sync bit, and checks the first output after the edge against the new phase offset alone. It then checks that the next output moves by the new step. It also writes and reads one address in the same cycle. The read must return the old value before the edge and the new one after it. A behavioural model compares every cycle of a long random write sequence.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  // register addresses and bit positions that software relies on
  localparam int unsigned CTRL_ADDR  = 'h02;
  localparam int unsigned POW_BASE   = 'h12;
  localparam int unsigned FTW_BASE   = 'h14;
  localparam int unsigned SYNC_ADDR  = 'h1F;
  localparam int unsigned EN_MIX_BIT = 6;
  localparam int unsigned EN_NCO_BIT = 4;
  localparam int unsigned SYNC_BIT   = 1;
endpackage

// File: rtl/nco_ctrl_regs.sv
`timescale 1ns/1ps
module nco_ctrl_regs
  import nco_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              sync_o,
  output logic              en_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] SYNC_A = ADDR_W'(SYNC_ADDR);

  logic [REG_W-1:0] ctrl_q, sync_q;
  logic ctrl_wr, sync_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_A);
  assign sync_wr = wr_en_i && (wr_addr_i == SYNC_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sync_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data_i;
      if (sync_wr) sync_q <= wr_data_i;
    end
  end

  // rising edge of the sync bit, seen at the write itself
  assign sync_o = sync_wr && wr_data_i[SYNC_BIT] && !sync_q[SYNC_BIT];
  assign en_o   = ctrl_q[EN_MIX_BIT] && ctrl_q[EN_NCO_BIT];

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CTRL_A) rd_data_o = ctrl_q;
    if (rd_addr_i == SYNC_A) rd_data_o = sync_q;
  end
endmodule

// File: rtl/nco_tune_bank.sv
`timescale 1ns/1ps
module nco_tune_bank
  import nco_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 16,
  parameter int ACC_W  = 32,
  parameter int CH_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              sync_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [ACC_W-1:0]  ftw_act_o,
  output logic [REG_W-1:0]  pow_act_o
);
  localparam int PARTS = ACC_W / REG_W;
  localparam logic [ADDR_W-1:0] POW_A = ADDR_W'(POW_BASE + CH_IDX);

  function automatic logic [ADDR_W-1:0] part_addr(input int p);
    return ADDR_W'(FTW_BASE + CH_IDX * PARTS + p);
  endfunction

  logic [PARTS-1:0][REG_W-1:0] ftw_shd_q, ftw_act_q;
  logic [REG_W-1:0]            pow_shd_q, pow_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_shd_q <= '0;
      ftw_act_q <= '0;
      pow_shd_q <= '0;
      pow_act_q <= '0;
    end else begin
      for (int p = 0; p < PARTS; p++) begin
        if (wr_en_i && (wr_addr_i == part_addr(p))) ftw_shd_q[p] <= wr_data_i;
      end
      if (wr_en_i && (wr_addr_i == POW_A)) pow_shd_q <= wr_data_i;
      // sync is a write to another address, so shadows are stable here
      if (sync_i) begin
        ftw_act_q <= ftw_shd_q;
        pow_act_q <= pow_shd_q;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == POW_A) rd_data_o = pow_shd_q;
    for (int p = 0; p < PARTS; p++) begin
      if (rd_addr_i == part_addr(p)) rd_data_o = ftw_shd_q[p];
    end
  end

  assign ftw_act_o = ftw_act_q;
  assign pow_act_o = pow_act_q;
endmodule

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [PH_W-1:0]  pow_i,
  output logic [PH_W-1:0]  phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (sync_i) acc_q <= '0;  // clear wins over the step
    else             acc_q <= acc_q + ftw_i;
  end

  assign phase_o = en_i ? (acc_q[ACC_W-1 -: PH_W] + pow_i) : '0;
endmodule

// File: rtl/nco_dual_stage.sv
`timescale 1ns/1ps
module nco_dual_stage
  import nco_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int REG_W  = 16,
  parameter int ACC_W  = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [REG_W-1:0]             wr_data_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [REG_W-1:0]             rd_data_o,
  output logic [NUM_CH-1:0][REG_W-1:0] phase_o
);
  localparam int PH_W = REG_W;

  logic                         sync_w;
  logic                         nco_en_w;
  logic [REG_W-1:0]             ctrl_rd_w;
  logic [NUM_CH-1:0][REG_W-1:0] bank_rd_w;
  logic [NUM_CH-1:0][ACC_W-1:0] ftw_act_w;
  logic [NUM_CH-1:0][PH_W-1:0]  pow_act_w;

  nco_ctrl_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (ctrl_rd_w),
    .sync_o    (sync_w),
    .en_o      (nco_en_w)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    nco_tune_bank #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .ACC_W(ACC_W), .CH_IDX(ch)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_addr_i (rd_addr_i),
      .sync_i    (sync_w),
      .rd_data_o (bank_rd_w[ch]),
      .ftw_act_o (ftw_act_w[ch]),
      .pow_act_o (pow_act_w[ch])
    );

    nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync_w),
      .en_i    (nco_en_w),
      .ftw_i   (ftw_act_w[ch]),
      .pow_i   (pow_act_w[ch]),
      .phase_o (phase_o[ch])
    );
  end

  // each source returns zero on a miss
  always_comb begin
    rd_data_o = ctrl_rd_w;
    for (int ch = 0; ch < NUM_CH; ch++) rd_data_o = rd_data_o | bank_rd_w[ch];
  end
endmodule

// File: rtl/nco_dual_stage_chk.sv
`timescale 1ns/1ps
module nco_dual_stage_chk
  import nco_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int REG_W  = 16,
  parameter int ACC_W  = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wr_en_i,
  input logic [ADDR_W-1:0]            wr_addr_i,
  input logic [REG_W-1:0]             wr_data_i,
  input logic [ADDR_W-1:0]            rd_addr_i,
  input logic [REG_W-1:0]             rd_data_o,
  input logic [NUM_CH-1:0][REG_W-1:0] phase_o,
  input logic                         sync_w,
  input logic                         en_w,
  input logic [NUM_CH-1:0][ACC_W-1:0] ftw_act_w,
  input logic [NUM_CH-1:0][REG_W-1:0] pow_act_w
);
  localparam int PARTS = ACC_W / REG_W;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] SYNC_A = ADDR_W'(SYNC_ADDR);

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    int unsigned ai;
    ai = int'(a);
    return (a == CTRL_A) || (a == SYNC_A) ||
           (ai >= POW_BASE && ai < POW_BASE + NUM_CH) ||
           (ai >= FTW_BASE && ai < FTW_BASE + NUM_CH * PARTS);
  endfunction

  logic sync_bit_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_bit_q <= 1'b0;
    else if (wr_en_i && wr_addr_i == SYNC_A) sync_bit_q <= wr_data_i[SYNC_BIT];
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_w |=> ($stable(ftw_act_w) && $stable(pow_act_w))); // R4

  AST_SYNC_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_w |-> (wr_en_i && wr_addr_i == SYNC_A && wr_data_i[SYNC_BIT])); // R5

  AST_NO_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SYNC_A && sync_bit_q) |-> !sync_w); // R5

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_SYNC_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_w |=> (phase_o[c] == (en_w ? pow_act_w[c] : '0))); // R6
  end

  AST_DISABLED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CTRL_A && !(wr_data_i[EN_MIX_BIT] && wr_data_i[EN_NCO_BIT]))
    |=> (phase_o == '0)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_mapped(rd_addr_i) |-> (rd_data_o == '0)); // R9

  AST_READ_STAGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == rd_addr_i && is_mapped(wr_addr_i))
    |=> ((rd_addr_i != $past(rd_addr_i)) || (rd_data_o == $past(wr_data_i)))); // R10
endmodule

bind nco_dual_stage nco_dual_stage_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REG_W(REG_W), .ACC_W(ACC_W)
) i_nco_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .phase_o   (phase_o),
  .sync_w    (sync_w),
  .en_w      (nco_en_w),
  .ftw_act_w (ftw_act_w),
  .pow_act_w (pow_act_w)
);

// File: tb/test_nco_dual_stage.sv
`timescale 1ns/1ps
module test_nco_dual_stage;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [7:0]       wr_addr_i = '0;
  logic [15:0]      wr_data_i = '0;
  logic [7:0]       rd_addr_i = '0;
  logic [15:0]      rd_data_o;
  logic [1:0][15:0] phase_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk_i = ~clk_i;  // 200 MHz

  nco_dual_stage i_nco_dual_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .phase_o(phase_o)
  );

  // behavioural reference
  logic [31:0] m_sftw [2];
  logic [31:0] m_aftw [2];
  logic [31:0] m_acc  [2];
  logic [15:0] m_spow [2];
  logic [15:0] m_apow [2];
  logic [15:0] m_ctrl, m_sync;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        m_sftw[c] = 0; m_aftw[c] = 0; m_acc[c] = 0; m_spow[c] = 0; m_apow[c] = 0;
      end
      m_ctrl = 0; m_sync = 0;
    end else begin
      logic s;
      s = wr_en_i && wr_addr_i == 8'h1F && wr_data_i[1] && !m_sync[1];
      for (int c = 0; c < 2; c++) begin
        if (s) begin
          m_acc[c] = 0; m_aftw[c] = m_sftw[c]; m_apow[c] = m_spow[c];
        end else m_acc[c] = m_acc[c] + m_aftw[c];
      end
      if (wr_en_i) begin
        case (wr_addr_i)
          8'h02: m_ctrl = wr_data_i;
          8'h1F: m_sync = wr_data_i;
          8'h12: m_spow[0] = wr_data_i;
          8'h13: m_spow[1] = wr_data_i;
          8'h14: m_sftw[0][15:0]  = wr_data_i;
          8'h15: m_sftw[0][31:16] = wr_data_i;
          8'h16: m_sftw[1][15:0]  = wr_data_i;
          8'h17: m_sftw[1][31:16] = wr_data_i;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] exp_phase(input int c);
    logic [31:0] a;
    a = m_acc[c];
    return (m_ctrl[6] && m_ctrl[4]) ? 16'(a[31:16] + m_apow[c]) : 16'h0;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h02: return m_ctrl;
      8'h1F: return m_sync;
      8'h12: return m_spow[0];
      8'h13: return m_spow[1];
      8'h14: return m_sftw[0][15:0];
      8'h15: return m_sftw[0][31:16];
      8'h16: return m_sftw[1][15:0];
      8'h17: return m_sftw[1][31:16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (cmp_on && rst_ni) begin
      for (int c = 0; c < 2; c++)
        check((m_ctrl[6] && m_ctrl[4]) ? "R7 model phase" : "R8 model phase",
              32'(phase_o[c]), 32'(exp_phase(c)));
      check("R9 model read", 32'(rd_data_o), 32'(exp_rd(rd_addr_i)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
    @(posedge clk_i); #1;
    rd_addr_i = a;
    @(negedge clk_i);
    check(tag, 32'(rd_data_o), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] p;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 phase0 reset", 32'(phase_o[0]), 0);
    check("R1 phase1 reset", 32'(phase_o[1]), 0);
    rd_chk("R1 read 0x14 reset", 8'h14, 16'h0);
    rd_chk("R1 read 0x02 reset", 8'h02, 16'h0);
    cmp_on = 1'b1;

    wr(8'h02, 16'h0050);
    wr(8'h14, 16'h0000); wr(8'h15, 16'h0001);
    wr(8'h16, 16'h8000); wr(8'h17, 16'h0003);
    wr(8'h12, 16'h0100); wr(8'h13, 16'hFFFF);
    rd_chk("R2 read 0x15", 8'h15, 16'h0001);
    rd_chk("R2 read 0x16", 8'h16, 16'h8000);
    rd_chk("R2 read 0x17", 8'h17, 16'h0003);
    rd_chk("R3 read 0x12", 8'h12, 16'h0100);
    rd_chk("R3 read 0x13", 8'h13, 16'hFFFF);
    @(negedge clk_i);
    check("R4 staged not active ch0", 32'(phase_o[0]), 0);
    check("R4 staged not active ch1", 32'(phase_o[1]), 0);

    // sync edge: clear beats the accumulation step
    wr(8'h1F, 16'h0002);
    @(negedge clk_i);
    check("R6 ch0 after sync", 32'(phase_o[0]), 32'h0100);
    check("R6 ch1 after sync", 32'(phase_o[1]), 32'hFFFF);
    @(negedge clk_i);
    check("R7 ch0 one step", 32'(phase_o[0]), 32'h0101);
    check("R7 ch1 one step wraps", 32'(phase_o[1]), 32'h0002);

    // level-high rewrite is not an edge
    wr(8'h14, 16'h0000); wr(8'h15, 16'h0002);
    @(negedge clk_i);
    p = phase_o[0];
    wr(8'h1F, 16'h0002);
    @(negedge clk_i);
    check("R5 no sync on held bit", 32'(phase_o[0]), 32'(16'(p + 16'd2)));
    wr(8'h1F, 16'h0000);
    wr(8'h1F, 16'h0002);
    @(negedge clk_i);
    check("R5 re-armed sync clears", 32'(phase_o[0]), 32'h0100);
    @(negedge clk_i);
    check("R5 new step active", 32'(phase_o[0]), 32'h0102);

    // enable gating
    wr(8'h02, 16'h0040);
    @(negedge clk_i);
    check("R8 disabled ch0", 32'(phase_o[0]), 0);
    check("R8 disabled ch1", 32'(phase_o[1]), 0);
    wr(8'h02, 16'h0050);
    @(negedge clk_i);
    p = phase_o[0];
    @(negedge clk_i);
    check("R8 accumulator kept running", 32'(phase_o[0]), 32'(16'(p + 16'd2)));

    rd_chk("R9 unmapped 0x00", 8'h00, 16'h0);
    rd_chk("R9 unmapped 0x11", 8'h11, 16'h0);
    rd_chk("R9 unmapped 0x18", 8'h18, 16'h0);
    rd_chk("R9 unmapped 0xFF", 8'hFF, 16'h0);
    rd_chk("R9 sync reg readback", 8'h1F, 16'h0002);
    rd_chk("R9 ctrl readback", 8'h02, 16'h0050);

    // write and read one address in the same cycle
    @(posedge clk_i); #1;
    rd_addr_i = 8'h12; wr_en_i = 1'b1; wr_addr_i = 8'h12; wr_data_i = 16'h1234;
    @(negedge clk_i);
    check("R10 old value before edge", 32'(rd_data_o), 32'h0100);
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    @(negedge clk_i);
    check("R10 new value after edge", 32'(rd_data_o), 32'h1234);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(posedge clk_i); #1;
      wr_en_i = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 9))
        0: begin
          wr_addr_i = 8'h02;
          wr_data_i = ($urandom_range(0, 3) != 0) ? 16'h0050 : 16'($urandom);
        end
        7, 8: begin
          wr_addr_i = 8'h1F;
          wr_data_i = 16'($urandom_range(0, 3) << 1);
        end
        9: begin
          wr_addr_i = 8'($urandom);
          wr_data_i = 16'($urandom);
        end
        default: begin
          wr_addr_i = 8'($urandom_range(8'h12, 8'h17));
          wr_data_i = 16'($urandom);
        end
      endcase
      rd_addr_i = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(8'h10, 8'h1F)) : 8'($urandom);
    end
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    repeat (4) @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule